// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit processor core with five pipeline stages: fetch, decode, execute, memory access and writeback. It runs a small load/store instruction set of five register-register ALU operations, an add-immediate, a word load, a word store and a branch-if-equal. Instruction memory and data memory sit outside the core. Instruction memory is read combinationally from the fetch address. Data memory is read combinationally and written on the clock edge while the write strobe is high.

The branch is resolved in decode. The two source registers are compared there, and the target is computed there from the incremented PC and the shifted offset. The instruction that follows a branch is always executed. The core does not forward results between stages. Software keeps a consumer at least three instructions behind its producer. A stall input holds fetch and decode when the surrounding logic detects a conflict.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, the fetch address becomes 0 (parameter `RESET_PC`) and every pipeline stage is emptied. In the cycle after reset is released, `imem_addr` is 0 and `dmem_we` is low.
- R2: Without a stall and without a taken branch, `imem_addr` advances by 4 on every clock.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A performs add, subtract, AND, OR and signed set-less-than on rs (bits 25:21) and rt (bits 20:16), and writes the result to rd (bits 15:11).
- R4: Opcode 0x08 adds the sign-extended 16-bit immediate (bits 15:0) to rs and writes the sum to rt.
- R5: Opcode 0x23 (load) and opcode 0x2B (store) form the address rs + sign-extended immediate. A load writes the memory word to rt. A store drives rt on `dmem_wdata` with `dmem_we` high for one cycle.
- R6: Register 0 always reads as zero. Writes to register 0 are discarded.
- R7: A register written in writeback is seen by the instruction in decode during the same cycle. A consumer placed three instructions after its producer therefore gets the new value.
- R8: Opcode 0x04 compares rs and rt in decode. When they are equal, the next fetch address is PC+4 + (offset << 2). Otherwise fetch continues in sequence.
- R9: The single instruction after a branch executes, whether or not the branch is taken. The instruction after that slot is skipped when the branch is taken.
- R10: While `stall` is high, the PC and the fetch/decode register hold, and an empty operation (no register or memory write) enters execute. Program results are the same as without the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds fetch and decode and inserts an empty operation |
| imem_addr | output | 32 | Instruction fetch byte address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bench builds the core with its default parameters: a reset PC of 0 and a fixed 32-bit datapath. The program therefore starts at word 0 of a 64-word instruction store. A scoreboard predicts every store the program makes, with its address and data, in order. The ALU, immediate, load, register-zero, taken-branch, not-taken-branch and delay-slot outcomes all show up at the data port. A multi-cycle stall in the middle of the ALU sequence shows that the fetch address is held and that the predicted results are unchanged.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;
  localparam int IMM_W  = 16;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_to_reg;
    logic    mem_we;
    logic    use_imm;
    logic    dst_rd;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc_next,
                                                  input logic [XLEN-1:0] off);
    return pc_next + {off[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];
  logic         wr_live;

  // A write to register zero is dropped here and in the bypass.
  assign wr_live = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wa] <= wd;
    end
  end

  // Same-cycle visibility: a value being written now is returned at once.
  always_comb begin
    if (ra_a == '0)                  rd_a = '0;
    else if (wr_live && wa == ra_a)  rd_a = wd;
    else                             rd_a = regs[ra_a];
    if (ra_b == '0)                  rd_b = '0;
    else if (wr_live && wa == ra_b)  rd_b = wd;
    else                             rd_b = regs[ra_b];
  end
endmodule

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output logic       is_beq
);
  always_comb begin
    ctrl   = ctrl_t'('0);
    is_beq = 1'b0;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl = ctrl_t'('0);
        endcase
      end
      OPC_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_ADD;
      end
      OPC_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_op     = ALU_ADD;
      end
      OPC_STOR: begin
        ctrl.mem_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_ADD;
      end
      OPC_BEQ: is_beq = 1'b1;
      default: ctrl = ctrl_t'('0);
    endcase
  end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q, pc_seq;
  logic [XLEN-1:0] fd_instr, fd_pc4;

  assign pc_seq    = pc_q + PC_STEP;
  assign imem_addr = pc_q;

  // ---------------- decode ----------------
  logic [5:0]        id_opc, id_fn;
  logic [REG_AW-1:0] id_rs, id_rt, id_rd;
  logic [XLEN-1:0]   id_rs_val, id_rt_val, id_imm, br_target;
  ctrl_t             id_ctrl;
  logic              id_beq, br_taken;

  assign id_opc = fd_instr[31:26];
  assign id_rs  = fd_instr[25:21];
  assign id_rt  = fd_instr[20:16];
  assign id_rd  = fd_instr[15:11];
  assign id_fn  = fd_instr[5:0];
  assign id_imm = sext_imm(fd_instr[IMM_W-1:0]);

  pipe5_ctrl u_ctrl (
    .opcode (id_opc),
    .funct  (id_fn),
    .ctrl   (id_ctrl),
    .is_beq (id_beq)
  );

  // writeback side (declared ahead of the register file)
  logic              wb_reg_we, wb_m2r;
  logic [REG_AW-1:0] wb_dst;
  logic [XLEN-1:0]   wb_alu, wb_mem, wb_val;

  pipe5_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (id_rs),
    .ra_b (id_rt),
    .rd_a (id_rs_val),
    .rd_b (id_rt_val),
    .we   (wb_reg_we),
    .wa   (wb_dst),
    .wd   (wb_val)
  );

  assign br_taken  = id_beq && (id_rs_val == id_rt_val);
  assign br_target = branch_dest(fd_pc4, id_imm);

  // PC and fetch/decode register; the slot after a branch is kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= RESET_PC;
      fd_instr <= '0;
      fd_pc4   <= '0;
    end else if (!stall) begin
      pc_q     <= br_taken ? br_target : pc_seq;
      fd_instr <= imem_rdata;
      fd_pc4   <= pc_seq;
    end
  end

  // ---------------- execute ----------------
  ctrl_t             ex_ctrl;
  logic [XLEN-1:0]   ex_a, ex_b, ex_imm, ex_srcb, ex_y;
  logic [REG_AW-1:0] ex_rt, ex_rd, ex_dst;

  always_ff @(posedge clk) begin
    if (rst || stall) begin
      ex_ctrl <= ctrl_t'('0);
      ex_a    <= '0;
      ex_b    <= '0;
      ex_imm  <= '0;
      ex_rt   <= '0;
      ex_rd   <= '0;
    end else begin
      ex_ctrl <= id_ctrl;
      ex_a    <= id_rs_val;
      ex_b    <= id_rt_val;
      ex_imm  <= id_imm;
      ex_rt   <= id_rt;
      ex_rd   <= id_rd;
    end
  end

  assign ex_srcb = ex_ctrl.use_imm ? ex_imm : ex_b;
  assign ex_dst  = ex_ctrl.dst_rd ? ex_rd : ex_rt;

  pipe5_alu u_alu (
    .op (ex_ctrl.alu_op),
    .a  (ex_a),
    .b  (ex_srcb),
    .y  (ex_y)
  );

  wire ex_reg_we = ex_ctrl.reg_we;
  wire ex_mem_we = ex_ctrl.mem_we;

  // ---------------- memory ----------------
  logic              mm_reg_we, mm_m2r, mm_mem_we;
  logic [XLEN-1:0]   mm_y, mm_sd;
  logic [REG_AW-1:0] mm_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mm_reg_we <= 1'b0;
      mm_m2r    <= 1'b0;
      mm_mem_we <= 1'b0;
      mm_y      <= '0;
      mm_sd     <= '0;
      mm_dst    <= '0;
    end else begin
      mm_reg_we <= ex_reg_we;
      mm_m2r    <= ex_ctrl.mem_to_reg;
      mm_mem_we <= ex_mem_we;
      mm_y      <= ex_y;
      mm_sd     <= ex_b;
      mm_dst    <= ex_dst;
    end
  end

  assign dmem_addr  = mm_y;
  assign dmem_wdata = mm_sd;
  assign dmem_we    = mm_mem_we;

  // ---------------- writeback ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_reg_we <= 1'b0;
      wb_m2r    <= 1'b0;
      wb_alu    <= '0;
      wb_mem    <= '0;
      wb_dst    <= '0;
    end else begin
      wb_reg_we <= mm_reg_we;
      wb_m2r    <= mm_m2r;
      wb_alu    <= mm_y;
      wb_mem    <= dmem_rdata;
      wb_dst    <= mm_dst;
    end
  end

  assign wb_val = wb_m2r ? wb_mem : wb_alu;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
  import pipe5_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic [XLEN-1:0]   imem_addr,
  input logic              dmem_we,
  input logic              br_taken,
  input logic [XLEN-1:0]   br_target,
  input logic              ex_reg_we,
  input logic              ex_mem_we,
  input logic [REG_AW-1:0] id_rs,
  input logic [XLEN-1:0]   id_rs_val
);
  // R1: leaving reset, fetch starts at zero with no store pending
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (imem_addr == '0) && !dmem_we);

  // R2: sequential fetch
  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !br_taken) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R8: a taken branch redirects fetch to the decode-stage target
  assert_branch_redirect_R8: assert property (@(posedge clk) disable iff (rst)
    (!stall && br_taken) |=> imem_addr == $past(br_target));

  // R10: stall freezes the PC
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(imem_addr));

  // R10: stall injects an empty operation into execute
  assert_stall_bubble_R10: assert property (@(posedge clk) disable iff (rst)
    stall |=> !ex_reg_we && !ex_mem_we);

  // R6: register zero reads as zero in decode
  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
    (id_rs == '0) |-> (id_rs_val == '0));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .br_taken  (br_taken),
  .br_target (br_target),
  .ex_reg_we (ex_reg_we),
  .ex_mem_we (ex_mem_we),
  .id_rs     (id_rs),
  .id_rs_val (id_rs_val)
);

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] addr; logic [31:0] data; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  pipe5_core u0 (
    .clk(clk), .rst(rst), .stall(stall),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rt_op(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_op(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.addr = a; e.data = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare each store with the oldest prediction
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5 unexpected store", dmem_addr, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(dmem_addr == e.addr && dmem_wdata == e.data, e.tag,
              (dmem_addr == e.addr) ? dmem_wdata : dmem_addr,
              (dmem_addr == e.addr) ? e.data : e.addr);
      end
    end
  end

  initial begin
    logic [31:0] held;
    bit timed_out;
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    dmem[32] = 32'h1234_5678;
    imem[0]  = it_op(6'h08, 0, 1, 16'd7);
    imem[1]  = it_op(6'h08, 0, 2, 16'hFFFD);
    imem[4]  = rt_op(6'h20, 1, 2, 3);
    imem[5]  = rt_op(6'h22, 1, 2, 4);
    imem[6]  = rt_op(6'h24, 1, 2, 5);
    imem[7]  = rt_op(6'h25, 1, 2, 6);
    imem[8]  = rt_op(6'h2A, 2, 1, 7);
    imem[9]  = rt_op(6'h2A, 1, 2, 8);
    imem[10] = it_op(6'h08, 0, 0, 16'd5);
    imem[11] = it_op(6'h23, 0, 9, 16'h0080);
    imem[12] = it_op(6'h08, 0, 10, 16'd1);
    imem[15] = it_op(6'h2B, 0, 3, 16'd0);
    imem[16] = it_op(6'h2B, 0, 4, 16'd4);
    imem[17] = it_op(6'h2B, 0, 5, 16'd8);
    imem[18] = it_op(6'h2B, 0, 6, 16'd12);
    imem[19] = it_op(6'h2B, 0, 7, 16'd16);
    imem[20] = it_op(6'h2B, 0, 8, 16'd20);
    imem[21] = it_op(6'h2B, 0, 0, 16'd24);
    imem[22] = it_op(6'h2B, 0, 9, 16'd28);
    imem[23] = it_op(6'h04, 10, 10, 16'd2);
    imem[24] = it_op(6'h08, 0, 11, 16'h0055);
    imem[25] = it_op(6'h08, 0, 12, 16'h0066);
    imem[26] = it_op(6'h08, 0, 14, 16'h0077);
    imem[27] = it_op(6'h04, 10, 0, 16'd2);
    imem[28] = it_op(6'h08, 0, 15, 16'd3);
    imem[29] = it_op(6'h08, 0, 16, 16'd2);
    imem[32] = it_op(6'h2B, 0, 11, 16'd32);
    imem[33] = it_op(6'h2B, 0, 12, 16'd36);
    imem[34] = it_op(6'h2B, 0, 14, 16'd40);
    imem[35] = it_op(6'h2B, 0, 15, 16'd44);
    imem[36] = it_op(6'h2B, 0, 16, 16'd48);
    imem[37] = it_op(6'h04, 0, 0, 16'hFFFF);

    expect_store(32'd0,  32'd4,          "R3 add R7");
    expect_store(32'd4,  32'd10,         "R3 sub");
    expect_store(32'd8,  32'd5,          "R3 and");
    expect_store(32'd12, 32'hFFFF_FFFF,  "R3 or R4 sign-extend");
    expect_store(32'd16, 32'd1,          "R3 slt true");
    expect_store(32'd20, 32'd0,          "R3 slt false");
    expect_store(32'd24, 32'd0,          "R6 zero register");
    expect_store(32'd28, 32'h1234_5678,  "R5 load");
    expect_store(32'd32, 32'h55,         "R9 delay slot taken");
    expect_store(32'd36, 32'h0,          "R8 skipped instruction");
    expect_store(32'd40, 32'h77,         "R8 branch target");
    expect_store(32'd44, 32'd3,          "R9 delay slot not taken");
    expect_store(32'd48, 32'd2,          "R8 fall-through");

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(imem_addr == 32'h0, "R1 pc after reset", imem_addr, 32'h0);
    check(dmem_we == 1'b0, "R1 no store after reset", {31'h0, dmem_we}, 32'h0);
    @(negedge clk);
    check(imem_addr == 32'h4, "R2 pc step", imem_addr, 32'h4);
    repeat (5) @(negedge clk);
    check(imem_addr == 32'h18, "R2 pc step", imem_addr, 32'h18);
    held = imem_addr;
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(imem_addr == held, "R10 pc held", imem_addr, held);
    end
    stall = 1'b0;

    timed_out = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (sb.size() == 0) begin timed_out = 1'b0; break; end
    end
    if (timed_out) check(1'b0, "watchdog", sb.size(), 0);
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule